// File: doc/BRIEF.md
# Timer and External Interrupt Control Register

This block is one byte-wide special-function register for an 8051-style CPU core. It holds the run enables and overflow flags of two timers, and the request flags and trigger-type selects of two active-low external interrupt pins. The CPU reads and writes the register through a simple SFR bus. The run enables drive the timers directly. Each flag also appears on its own request output, which an external interrupt controller watches.

Hardware sets a timer flag from a one-cycle overflow strobe. It sets a pin flag from pin activity after a two-flop synchronizer. Each flag has two clear paths: a software write, and a one-cycle acknowledge strobe that arrives when the CPU vectors to that source. Each pin has its own trigger type. In edge mode the pin flag latches on a falling edge. In level mode the pin flag is a live inverted copy of the synchronized pin level.

Top module: `tcon_reg`

## Requirements
- R1: A read at address ADDR (default 8'h88) returns the register, with bit layout [7] timer-1 flag, [6] timer-1 run, [5] timer-0 flag, [4] timer-0 run, [3] pin-1 flag, [2] pin-1 type, [1] pin-0 flag, [0] pin-0 type. A read at any other address returns 0, and a write at any other address has no effect.
- R2: After reset all eight bits read 0, and every output is 0.
- R3: A one-cycle overflow strobe for timer n sets that timer's flag at the next clock edge.
- R4: A write at ADDR stores the run and type bits. The run bits drive run_en[1:0] from the next edge.
- R5: In edge mode, a write at ADDR loads all four flags from the write data at the next edge. A 0 clears a flag and a 1 sets it.
- R6: An acknowledge strobe for a source clears that source's flag at the next edge.
- R7: When a hardware set and a clear (write or acknowledge) arrive in the same cycle, the flag ends up set.
- R8: With type bit = 1 (edge mode), a high-to-low transition on the pin sets the pin flag two edges after the synchronizer sees it. The flag stays set until software clears it or the source is acknowledged. A low-to-high transition never sets it.
- R9: With type bit = 0 (level mode), the pin flag equals the inverse of the synchronized pin. Writes and acknowledges to that flag have no lasting effect.
- R10: t_irq[n] and x_irq[n] always equal the matching timer and pin flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | SFR bus address |
| sfr_wr | input | 1 | Write strobe |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data; the register when addressed, else 0 |
| ovf_stb | input | 2 | Timer overflow strobes, bit n for timer n |
| t_ack | input | 2 | Timer interrupt acknowledge strobes |
| x_ack | input | 2 | External interrupt acknowledge strobes |
| xint_n | input | 2 | Asynchronous active-low interrupt pins |
| run_en | output | 2 | Timer run enables |
| t_irq | output | 2 | Timer interrupt requests |
| x_irq | output | 2 | External interrupt requests |

## Verification
The embedded assertions run on every cycle. They check that an overflow strobe always leaves its flag set, including when a clear arrives in the same cycle, and that an acknowledge with no competing set or write clears the flag. They also check that a synchronized falling edge in edge mode sets the pin flag, and that the request and run outputs always agree with the register as read. Some behaviours show only through the bench's directed scenarios: the end-to-end pin latency through the synchronizer, that a rising edge never sets the flag, and that writes and acknowledges leave no mark in level mode. The same holds for address decoding and the reset state.

// File: rtl/tcon_reg.sv
module tcon_reg #(
  parameter logic [7:0] ADDR = 8'h88
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] sfr_addr,
  input  logic       sfr_wr,
  input  logic [7:0] sfr_wdata,
  output logic [7:0] sfr_rdata,
  input  logic [1:0] ovf_stb,
  input  logic [1:0] t_ack,
  input  logic [1:0] x_ack,
  input  logic [1:0] xint_n,
  output logic [1:0] run_en,
  output logic [1:0] t_irq,
  output logic [1:0] x_irq
);

  logic [1:0] tf, tr, ie, it;
  logic [1:0] s1, s2, s3;
  logic [1:0] fall;
  logic       hit, wr_hit;
  logic [7:0] regv;

  assign hit    = (sfr_addr == ADDR);
  assign wr_hit = sfr_wr && hit;
  assign fall   = s3 & ~s2;
  assign regv   = {tf[1], tr[1], tf[0], tr[0], ie[1], it[1], ie[0], it[0]};
  assign sfr_rdata = hit ? regv : 8'h00;
  assign run_en = tr;
  assign t_irq  = tf;
  assign x_irq  = ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tf <= '0; tr <= '0; ie <= '0; it <= '0;
      s1 <= 2'b11; s2 <= 2'b11; s3 <= 2'b11;
    end else begin
      s1 <= xint_n;
      s2 <= s1;
      s3 <= s2;
      if (wr_hit) begin
        tr <= {sfr_wdata[6], sfr_wdata[4]};
        it <= {sfr_wdata[2], sfr_wdata[0]};
      end
      for (int i = 0; i < 2; i++) begin
        if (ovf_stb[i])      tf[i] <= 1'b1;
        else if (wr_hit)     tf[i] <= sfr_wdata[5 + 2*i];
        else if (t_ack[i])   tf[i] <= 1'b0;

        if (!it[i])          ie[i] <= ~s2[i];
        else if (fall[i])    ie[i] <= 1'b1;
        else if (wr_hit)     ie[i] <= sfr_wdata[1 + 2*i];
        else if (x_ack[i])   ie[i] <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_chk
    a_r3_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_stb[g] |=> t_irq[g]);
    a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_stb[g] && (t_ack[g] || wr_hit)) |=> t_irq[g]);
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (t_ack[g] && !ovf_stb[g] && !wr_hit) |=> !t_irq[g]);
    a_r8_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (it[g] && fall[g]) |=> x_irq[g]);
  end

  a_r10_irq_match: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (sfr_rdata[7] == t_irq[1] && sfr_rdata[5] == t_irq[0] &&
             sfr_rdata[3] == x_irq[1] && sfr_rdata[1] == x_irq[0]));
  a_r4_run_match: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (sfr_rdata[6] == run_en[1] && sfr_rdata[4] == run_en[0]));

endmodule

// File: tb/tcon_reg_test.sv
`timescale 1ns/1ps
module tcon_reg_test;
  logic       clk = 0, rst_n = 0;
  logic [7:0] sfr_addr = 8'h88, sfr_wdata = 0, sfr_rdata;
  logic       sfr_wr = 0;
  logic [1:0] ovf_stb = 0, t_ack = 0, x_ack = 0, xint_n = 2'b11;
  logic [1:0] run_en, t_irq, x_irq;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  tcon_reg uut (.clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .ovf_stb(ovf_stb), .t_ack(t_ack),
    .x_ack(x_ack), .xint_n(xint_n), .run_en(run_en), .t_irq(t_irq), .x_irq(x_irq));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1;
    tick(1);
    sfr_wr = 0; sfr_addr = 8'h88;
  endtask

  task automatic rd(input string req, input logic [7:0] exp);
    #0.5 chk(req, sfr_rdata, exp);
  endtask

  task automatic t_reset;
    rd("R2 reg", 8'h00);
    chk("R2 outs", {2'b0, run_en, t_irq, x_irq}, 8'h00);
  endtask

  task automatic t_rw;
    wr(8'h88, 8'h55); rd("R1 R4 write", 8'h55);
    chk("R4 run_en", {6'b0, run_en}, 8'h03);
    wr(8'h88, 8'hFF); rd("R5 flags set", 8'hFF);
    chk("R10 irq", {4'b0, t_irq, x_irq}, 8'h0F);
    wr(8'h89, 8'h00); rd("R1 foreign write", 8'hFF);
    sfr_addr = 8'h89; rd("R1 foreign read", 8'h00); sfr_addr = 8'h88;
    wr(8'h88, 8'h55); rd("R5 flags clear", 8'h55);
  endtask

  task automatic t_ovf;
    ovf_stb = 2'b01; tick(1); ovf_stb = 0;
    rd("R3 tf0 set", 8'h75);
    chk("R10 t_irq", {6'b0, t_irq}, 8'h01);
    t_ack = 2'b01; tick(1); t_ack = 0;
    rd("R6 tf0 ack", 8'h55);
    ovf_stb = 2'b10; t_ack = 2'b10; tick(1); ovf_stb = 0; t_ack = 0;
    rd("R7 ovf vs ack", 8'hD5);
    ovf_stb = 2'b01; sfr_wdata = 8'h55; sfr_wr = 1; tick(1); sfr_wr = 0; ovf_stb = 0;
    rd("R7 ovf vs write", 8'h75);
    wr(8'h88, 8'h05); rd("R5 clear all", 8'h05);
  endtask

  task automatic t_edge;
    xint_n[0] = 0; tick(3);
    rd("R8 fall sets", 8'h07);
    xint_n[0] = 1; tick(4);
    rd("R8 held", 8'h07);
    x_ack = 2'b01; tick(1); x_ack = 0;
    rd("R6 x ack", 8'h05);
    xint_n[0] = 0; tick(3); x_ack = 2'b01; tick(1); x_ack = 0;
    rd("R8 cleared while low", 8'h05);
    xint_n[0] = 1; tick(4);
    rd("R8 rise ignored", 8'h05);
  endtask

  task automatic t_level;
    wr(8'h88, 8'h00);
    xint_n[1] = 0; tick(3);
    rd("R9 low reads 1", 8'h08);
    chk("R10 x_irq", {6'b0, x_irq}, 8'h02);
    wr(8'h88, 8'h00); rd("R9 write ignored", 8'h08);
    x_ack = 2'b10; tick(1); x_ack = 0;
    rd("R9 ack ignored", 8'h08);
    xint_n[1] = 1; tick(3);
    rd("R9 high reads 0", 8'h00);
  endtask

  initial begin
    #500000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    t_reset();
    rst_n = 1; tick(2);
    t_reset();
    t_rw();
    t_ovf();
    t_edge();
    t_level();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule